// File: doc/BRIEF.md
# SPI Port with Word Request Handshake

This block is a serial port that works either as an SPI slave or as an SPI master. A mode input selects the role. Each data word is 8 bits, sent most significant bit first in SPI mode 0: data is sampled on the rising SCK edge and changed on the falling edge. On the parallel side the block takes a word with a one-cycle load strobe and returns each received word with a one-cycle valid strobe.

An active-low request pin paces the words, and its direction follows the mode. As a slave, the block drives the pin low once a word has been loaded for sending, and releases it on the first SCK rise of that word. As a master, the block reads the pin. It starts a loaded word only after it sees a fresh high-to-low change on the pin. When both request-enable bits are zero, the pin output is released and the master does not wait for it.

In master mode the block generates SCK from the system clock by an even divisor of at least 4. If the slave-select input goes low while the block is master, the block flags a bus error. This flag stays set until software writes a 1 to clear it. While the flag is set, the word in flight is dropped and the SCK and MOSI drivers are released. In slave mode, the SCK, MOSI, slave-select and request inputs pass through two-stage synchronizers.

Top module: `spi_hreq_port`

## Requirements
- R1: During reset and right after it, the following are all 0: sck_oe, mosi_oe, miso_oe, req_n_oe, bus_err, busy and rx_valid.
- R2: In slave mode with ss_n_i low, the block shifts in mosi_i on each rising sck_i edge, MSB first. After the 8th bit it presents the word on rx_data and pulses rx_valid high for exactly one clock.
- R3: In slave mode with ss_n_i low, miso_o carries the last word loaded with tx_valid, MSB first. The MSB is present before the first rising edge, and each following bit appears after a falling sck_i edge.
- R4: In slave mode with ss_n_i high, miso_oe is 0 and sck_i edges are ignored: no rx_valid appears, and the next selected word starts again at its MSB.
- R5: In slave mode, req_n_o goes to 0 after a word is loaded with tx_valid. It returns to 1 after the first rising sck_i edge of the word that carries it.
- R6: req_n_oe is 1 only when reset is not active, cfg_master is 0, and cfg_req_en is nonzero. It is 0 in master mode and when cfg_req_en is 00.
- R7: In master mode, a word loaded with tx_valid is sent on mosi_o MSB first. SCK idles low and rises in the middle of each bit. miso_i is sampled at each rise, and the received word arrives with a one-cycle rx_valid.
- R8: In master mode, each SCK half period lasts max(cfg_div/2, 2) system clocks, with the division rounded down. For example, 6 gives 3, and any value below 4 gives 2.
- R9: In master mode with cfg_req_en nonzero, a loaded word starts only after a high-to-low change of the synchronized req_n_i. That change must occur after the previous word started, so a request held low does not start a second word. With cfg_req_en 00, a loaded word starts without waiting.
- R10: A low ss_n_i in master mode sets bus_err. bus_err stays set after ss_n_i goes high, and err_clr clears it. While bus_err is set, busy is 0, no rx_valid appears for the dropped word, and sck_oe and mosi_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 selects master role, 0 slave role |
| cfg_req_en | input | 2 | Request-pin enable bits; 00 disables the handshake |
| cfg_div | input | 8 | Master SCK divisor in system clocks (even, 4 or more) |
| err_clr | input | 1 | Write-1 pulse that clears bus_err |
| tx_data | input | 8 | Word to send |
| tx_valid | input | 1 | Load strobe for tx_data |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Master word in progress |
| bus_err | output | 1 | Sticky bus error flag |
| sck_i | input | 1 | SCK pin input (slave role) |
| sck_o | output | 1 | SCK pin output (master role) |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input (slave role) |
| mosi_o | output | 1 | MOSI pin output (master role) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input (master role) |
| miso_o | output | 1 | MISO pin output (slave role) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low slave select |
| req_n_i | input | 1 | Request pin input (master role) |
| req_n_o | output | 1 | Request pin output (slave role) |
| req_n_oe | output | 1 | Request pin output enable |

## Verification
The hardest situation to reach is the master holding a word while the external request stays low after a completed word. The master must treat that level as stale and wait. The bench finishes one request-paced word, keeps req_n_i low, and loads a second word. It then confirms over many clocks that SCK never moves and no word arrives. Only after that does it raise and lower the pin, and it checks that the held word then goes out intact. The bus-error abort is reached the same way: the bench pulls slave select low in the middle of a slow master word, then checks that the dropped word never produces a valid strobe.

// File: rtl/spi_hreq_pkg.sv
package spi_hreq_pkg;

    localparam int WORD_W = 8;
    localparam int DIV_W  = 8;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_LOW,
        MS_HIGH
    } mst_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              WIDTH  = 1,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng
    import spi_hreq_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic         ss_n_s,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         miso_o,
    output logic         miso_oe,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         ready
);
    localparam int CW = $clog2(W);

    logic          sck_d;
    logic [CW-1:0] cnt;
    logic [W-1:0]  tx_hold;
    logic [W-1:0]  sh_tx;
    logic [W-2:0]  sh_rx;
    edge_t         e;

    assign e = edge_of(sck_s, sck_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b0;
            cnt      <= '0;
            tx_hold  <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            ready    <= 1'b0;
        end else begin
            sck_d    <= sck_s;
            rx_valid <= 1'b0;
            if (tx_valid) begin
                tx_hold <= tx_data;
                ready   <= 1'b1;
            end
            if (!en || ss_n_s) begin
                cnt <= '0;
            end else if (e.rise) begin
                sh_rx <= {sh_rx[W-3:0], mosi_s};
                if (cnt == '0) begin
                    sh_tx <= tx_hold;
                    ready <= 1'b0;
                end
                if (cnt == CW'(W-1)) begin
                    cnt      <= '0;
                    rx_data  <= {sh_rx, mosi_s};
                    rx_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (e.fall && cnt != '0) begin
                sh_tx <= {sh_tx[W-2:0], 1'b0};
            end
        end
    end

    assign miso_o  = (cnt == '0) ? tx_hold[W-1] : sh_tx[W-1];
    assign miso_oe = en & ~ss_n_s;
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng
    import spi_hreq_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          abort,
    input  logic [DW-1:0] div,
    input  logic          req_gate,
    input  logic          req_n_s,
    input  logic [W-1:0]  tx_data,
    input  logic          tx_valid,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          mosi_o,
    output logic [W-1:0]  rx_data,
    output logic          rx_valid,
    output logic          busy
);
    localparam int CW = $clog2(W);

    mst_state_e    st;
    logic [DW-1:0] half;
    logic [DW-1:0] hcnt;
    logic [CW-1:0] bcnt;
    logic [W-1:0]  tx_buf;
    logic [W-1:0]  sh_tx;
    logic [W-1:0]  sh_rx;
    logic          pend;
    logic          armed;
    logic          req_d;

    always_comb begin
        half = div >> 1;
        if (half < DW'(2)) half = DW'(2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= MS_IDLE;
            hcnt     <= '0;
            bcnt     <= '0;
            tx_buf   <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            pend     <= 1'b0;
            armed    <= 1'b0;
            req_d    <= 1'b1;
            sck_o    <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            req_d    <= req_n_s;
            rx_valid <= 1'b0;
            if (req_d && !req_n_s) armed <= 1'b1;
            if (tx_valid) begin
                tx_buf <= tx_data;
                pend   <= 1'b1;
            end
            if (!en || abort) begin
                st    <= MS_IDLE;
                sck_o <= 1'b0;
                pend  <= 1'b0;
            end else begin
                unique case (st)
                    MS_IDLE: if (pend && (armed || !req_gate)) begin
                        st    <= MS_LOW;
                        sh_tx <= tx_buf;
                        pend  <= 1'b0;
                        armed <= 1'b0;
                        hcnt  <= '0;
                        bcnt  <= '0;
                    end
                    MS_LOW: if (hcnt == half - 1'b1) begin
                        hcnt  <= '0;
                        st    <= MS_HIGH;
                        sck_o <= 1'b1;
                        sh_rx <= {sh_rx[W-2:0], miso_i};
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                    MS_HIGH: if (hcnt == half - 1'b1) begin
                        hcnt  <= '0;
                        sck_o <= 1'b0;
                        if (bcnt == CW'(W-1)) begin
                            st       <= MS_IDLE;
                            rx_data  <= sh_rx;
                            rx_valid <= 1'b1;
                        end else begin
                            st    <= MS_LOW;
                            bcnt  <= bcnt + 1'b1;
                            sh_tx <= {sh_tx[W-2:0], 1'b0};
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                    default: st <= MS_IDLE;
                endcase
            end
        end
    end

    assign mosi_o = sh_tx[W-1];
    assign busy   = (st != MS_IDLE);
endmodule

// File: rtl/spi_hreq_port.sv
module spi_hreq_port
    import spi_hreq_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int DW = DIV_W,
    parameter int NS = SYNC_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_master,
    input  logic [1:0]    cfg_req_en,
    input  logic [DW-1:0] cfg_div,
    input  logic          err_clr,
    input  logic [W-1:0]  tx_data,
    input  logic          tx_valid,
    output logic [W-1:0]  rx_data,
    output logic          rx_valid,
    output logic          busy,
    output logic          bus_err,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i,
    input  logic          req_n_i,
    output logic          req_n_o,
    output logic          req_n_oe
);
    logic [3:0]   pins_s;
    logic         ss_n_s, req_n_s, sck_s, mosi_s;
    logic [W-1:0] s_rx_data, m_rx_data;
    logic         s_rx_valid, m_rx_valid;
    logic         s_ready;
    logic         req_gate;

    spi_sync #(.WIDTH(4), .STAGES(NS), .INIT(4'b1100)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_i, req_n_i, sck_i, mosi_i}),
        .q   (pins_s)
    );
    assign {ss_n_s, req_n_s, sck_s, mosi_s} = pins_s;
    assign req_gate = |cfg_req_en;

    always_ff @(posedge clk) begin
        if (rst)                       bus_err <= 1'b0;
        else if (cfg_master && !ss_n_s) bus_err <= 1'b1;
        else if (err_clr)              bus_err <= 1'b0;
    end

    spi_slave_eng #(.W(W)) slv_i (
        .clk      (clk),
        .rst      (rst),
        .en       (~cfg_master),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ss_n_s   (ss_n_s),
        .tx_data  (tx_data),
        .tx_valid (tx_valid & ~cfg_master),
        .miso_o   (miso_o),
        .miso_oe  (miso_oe),
        .rx_data  (s_rx_data),
        .rx_valid (s_rx_valid),
        .ready    (s_ready)
    );

    spi_master_eng #(.W(W), .DW(DW)) mst_i (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_master),
        .abort    (bus_err),
        .div      (cfg_div),
        .req_gate (req_gate),
        .req_n_s  (req_n_s),
        .tx_data  (tx_data),
        .tx_valid (tx_valid & cfg_master),
        .miso_i   (miso_i),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .rx_data  (m_rx_data),
        .rx_valid (m_rx_valid),
        .busy     (busy)
    );

    assign rx_data  = cfg_master ? m_rx_data  : s_rx_data;
    assign rx_valid = cfg_master ? m_rx_valid : s_rx_valid;
    assign sck_oe   = ~rst & cfg_master & ~bus_err;
    assign mosi_oe  = ~rst & cfg_master & ~bus_err;
    assign req_n_o  = ~s_ready;
    assign req_n_oe = ~rst & ~cfg_master & req_gate;
endmodule

// File: rtl/spi_hreq_port_chk.sv
module spi_hreq_port_chk (
    input logic clk,
    input logic rst,
    input logic cfg_master,
    input logic ss_n_i,
    input logic err_clr,
    input logic sck_o,
    input logic miso_oe,
    input logic req_n_oe,
    input logic rx_valid,
    input logic bus_err,
    input logic busy
);
    // R2
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err && !err_clr |=> bus_err);

    // R10
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err && $past(bus_err) |-> !busy);

    // R4
    miso_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_master && ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) |-> !miso_oe);

    // R6
    req_dir_chk: assert property (@(posedge clk) disable iff (rst)
        req_n_oe |-> !cfg_master);

    // R7
    sck_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) |-> busy);
endmodule

bind spi_hreq_port spi_hreq_port_chk chk_i (.*);

// File: tb/spi_hreq_port_tb_top.sv
`timescale 1ns/1ps
module spi_hreq_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_master = 1'b0;
    logic [1:0] cfg_req_en = 2'b01;
    logic [7:0] cfg_div = 8'd6;
    logic       err_clr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, busy, bus_err;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
    logic       ss_n_i = 1'b1, req_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       req_n_o, req_n_oe;

    int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
    logic [7:0] rx_last = '0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_hreq_port dut_i (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_req_en(cfg_req_en),
        .cfg_div(cfg_div), .err_clr(err_clr), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .bus_err(bus_err),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .req_n_i(req_n_i), .req_n_o(req_n_o), .req_n_oe(req_n_oe)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rx_valid) begin
        rx_cnt  <= rx_cnt + 1;
        rx_last <= rx_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // bench acts as master driving sck_i/mosi_i
    task automatic slave_word(input logic [7:0] mo, output logic [7:0] mi, output logic req_after);
        req_after = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = mo[i];
            clocks(8);
            mi[i] = miso_o;
            sck_i = 1'b1;
            clocks(8);
            if (i == 7) req_after = req_n_o;
            sck_i = 1'b0;
        end
        clocks(8);
    endtask

    // bench acts as slave reacting to sck_o
    task automatic master_xfer(input logic [7:0] sw, output logic [7:0] got, output int half);
        logic prev;
        int nrise = 0, nfall = 0, t_rise = 0;
        got = '0; half = 0;
        miso_i = sw[7];
        prev = sck_o;
        for (int t = 0; t < 3000 && nfall < 8; t++) begin
            @(negedge clk);
            if (sck_o && !prev) begin
                got = {got[6:0], mosi_o};
                nrise++;
                t_rise = cyc;
            end
            if (!sck_o && prev) begin
                half = cyc - t_rise;
                nfall++;
                if (nrise < 8) miso_i = sw[7-nrise];
            end
            prev = sck_o;
        end
        clocks(4);
    endtask

    task automatic t_reset();
        clocks(3);
        chk("R6 req_n_oe in reset", req_n_oe, 0);
        chk("R1 sck_oe in reset", sck_oe, 0);
        @(negedge clk) rst = 1'b0;
        cfg_req_en = 2'b00;
        clocks(2);
        chk("R1 oe after reset", {sck_oe, mosi_oe, miso_oe, req_n_oe}, 4'b0000);
        chk("R1 status after reset", {bus_err, busy, rx_valid}, 3'b000);
    endtask

    task automatic t_slave();
        logic [7:0] mi; logic ra; int c0;
        cfg_master = 1'b0; cfg_req_en = 2'b01;
        clocks(2);
        chk("R6 req_n_oe slave enabled", req_n_oe, 1);
        chk("R5 req idle before load", req_n_o, 1);
        load(8'hA5);
        clocks(2);
        chk("R5 req asserted after load", req_n_o, 0);
        ss_n_i = 1'b0;
        clocks(4);
        chk("R3 miso_oe selected", miso_oe, 1);
        c0 = rx_cnt;
        slave_word(8'h3C, mi, ra);
        chk("R5 req released after first rise", ra, 1);
        chk("R3 miso word", mi, 8'hA5);
        chk("R2 rx word count", rx_cnt - c0, 1);
        chk("R2 rx data", rx_last, 8'h3C);
        // second word in the same selection
        load(8'h81);
        slave_word(8'h7E, mi, ra);
        chk("R3 miso second word", mi, 8'h81);
        chk("R2 rx second data", rx_last, 8'h7E);
    endtask

    task automatic t_slave_desel();
        logic [7:0] mi; logic ra; int c0;
        ss_n_i = 1'b1;
        clocks(4);
        chk("R4 miso_oe deselected", miso_oe, 0);
        c0 = rx_cnt;
        load(8'h42);
        mosi_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            clocks(8); sck_i = 1'b1; clocks(8); sck_i = 1'b0;
        end
        clocks(8);
        chk("R4 no rx while deselected", rx_cnt - c0, 0);
        chk("R4 miso_oe stays off", miso_oe, 0);
        ss_n_i = 1'b0;
        clocks(4);
        slave_word(8'hE1, mi, ra);
        chk("R4 word restarts at MSB rx", rx_last, 8'hE1);
        chk("R4 word restarts at MSB tx", mi, 8'h42);
        ss_n_i = 1'b1;
        cfg_req_en = 2'b00;
        clocks(2);
        chk("R6 req_n_oe with enables clear", req_n_oe, 0);
        cfg_req_en = 2'b10;
        clocks(2);
        chk("R6 req_n_oe with upper enable", req_n_oe, 1);
    endtask

    task automatic t_master_req();
        logic [7:0] got; int half, c0;
        cfg_master = 1'b1; cfg_req_en = 2'b01; cfg_div = 8'd6; req_n_i = 1'b1;
        clocks(4);
        chk("R6 req_n_oe off in master", req_n_oe, 0);
        chk("R7 sck/mosi enabled", {sck_oe, mosi_oe}, 2'b11);
        load(8'h96);
        clocks(40);
        chk("R9 waits for request", {busy, sck_o}, 2'b00);
        req_n_i = 1'b0;
        c0 = rx_cnt;
        master_xfer(8'h5A, got, half);
        chk("R7 mosi word", got, 8'h96);
        chk("R7 rx word", rx_last, 8'h5A);
        chk("R7 one rx strobe", rx_cnt - c0, 1);
        chk("R8 half period div 6", half, 3);
        load(8'hC3);
        c0 = rx_cnt;
        clocks(60);
        chk("R9 held request ignored", {busy, sck_o}, 2'b00);
        chk("R9 no word on stale request", rx_cnt - c0, 0);
        req_n_i = 1'b1; clocks(5); req_n_i = 1'b0;
        master_xfer(8'h0F, got, half);
        chk("R9 fresh request starts held word", got, 8'hC3);
        chk("R7 rx after fresh request", rx_last, 8'h0F);
    endtask

    task automatic t_master_free();
        logic [7:0] got; int half;
        cfg_req_en = 2'b00; cfg_div = 8'd1;
        load(8'h81);
        master_xfer(8'hB4, got, half);
        chk("R9 no-wait mosi word", got, 8'h81);
        chk("R8 half period clamped", half, 2);
        chk("R7 rx no-wait word", rx_last, 8'hB4);
    endtask

    task automatic t_bus_err();
        int c0;
        cfg_div = 8'd16;
        c0 = rx_cnt;
        load(8'hFF);
        clocks(20);
        chk("R10 busy before error", busy, 1);
        ss_n_i = 1'b0;
        clocks(5);
        chk("R10 bus_err set", bus_err, 1);
        chk("R10 drivers released", {sck_oe, mosi_oe, busy}, 3'b000);
        ss_n_i = 1'b1;
        clocks(200);
        chk("R10 bus_err sticky", bus_err, 1);
        chk("R10 dropped word no rx", rx_cnt - c0, 0);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        clocks(2);
        chk("R10 bus_err cleared", bus_err, 0);
        chk("R10 drivers back", {sck_oe, mosi_oe}, 2'b11);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_slave();
        t_slave_desel();
        t_master_req();
        t_master_free();
        t_bus_err();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule